// File: doc/BRIEF.md
# Multi-Bank DRAM Strobe Sequencer

This block turns single memory requests from a processor-side port into the strobe sequence that a set of five multiplexed-address DRAM banks expects. Each bank is nine bits wide. The request address is split into a bank index, a row half and a column half. The row half goes onto a shared multiplexed address bus and is latched by the row strobe of the chosen bank. The column half then replaces it on the same bus and is latched by a column strobe that all banks share. The block also drives an active-low write enable and controls the enable and direction of the data-bus transceiver.

A refresh request causes a row-only cycle. In that cycle every bank's row strobe falls at the same time, and the row address comes from an internal counter. A refresh is kept pending while a processor cycle runs, and it is served before any processor request that has not yet been accepted. A parameter selects 8-bit halves (256 by 256 devices) or 9-bit halves (512 by 512 devices). Each phase of the sequence lasts for a number of cycles set by a parameter.

Top module: `dram_bank_seq`

## Requirements
- R1: After reset, and whenever no cycle runs, all row strobes, the column strobe, write enable and transceiver enable are high, `ma` is zero and `req_ack` is low.
- R2: `req_addr` is {bank[2:0], row, col}, with the column half in the low bits. For bank 0 to 4, only `ras_n[bank]` goes low, and it stays low without change for the whole cycle.
- R3: A request with bank index 5, 6 or 7 is acknowledged but drives no row strobe, no column strobe and no transceiver enable.
- R4: `ma` holds the row half when the row strobe falls, and holds it one cycle earlier too. It holds the column half when `cas_n` falls.
- R5: With WIDE_ADDR=1 each half is 9 bits and `ma[8]` carries the top bit. With WIDE_ADDR=0 each half is 8 bits and `ma[8]` stays 0.
- R6: `we_n` is 0 during the column phase of a write (req_write=1) and is 1 for the whole of a read.
- R7: `xcvr_en_n` is low only while `cas_n` is low and `ram_sel_n` is low. `xcvr_dir` is 1 (system to RAM) for a write and 0 (RAM to system) for a read.
- R8: A processor cycle holds its row strobe low for T_RAS+T_COLSW+T_CAS+T_DATA cycles. The gap from a strobe rise to the next strobe fall is T_PRE+1+T_SETUP cycles.
- R9: A refresh pulls all five row strobes low together for T_RAS cycles, with `cas_n` held high and `ma` equal to the refresh row.
- R10: The refresh row is 0 after reset, goes up by one after each refresh, and wraps at 2^(half width).
- R11: A refresh request in the same cycle as an idle request wins: `req_ack` stays low, and the request is accepted only after the refresh cycle has finished.
- R12: A refresh requested during a processor cycle does not shorten that cycle. It is kept and served straight after the cycle's precharge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Processor request pending (held until acknowledged) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | {bank, row, col} |
| req_ack | output | 1 | Request accepted this cycle |
| refresh_req | input | 1 | Refresh request pulse |
| ram_sel_n | input | 1 | Active-low RAM select gating the transceiver |
| ma | output | 9 | Multiplexed row/column address bus |
| ras_n | output | NUM_BANKS | Per-bank active-low row strobes |
| cas_n | output | 1 | Shared active-low column strobe |
| we_n | output | 1 | Active-low write enable |
| xcvr_en_n | output | 1 | Active-low data transceiver enable |
| xcvr_dir | output | 1 | Transceiver direction, 1 = toward RAM |

## Verification
Random requests cover all eight bank codes, full-width row and column halves, both directions and both RAM-select levels. This separates a wrong bank decode from a swap of the row and column halves, and a write-enable fault from a transceiver-gating fault. Directed cases start a refresh together with a request and start one in the middle of a cycle, which separates refresh priority from cycle truncation. A run of more than 512 refreshes checks that the row counter wraps. A second instance built with 8-bit halves shows that the top address line stays unused in that mode.

// File: rtl/dram_seq_pkg.sv
package dram_seq_pkg;
    localparam int MA_W = 9;

    typedef enum logic [2:0] {
        ST_IDLE, ST_ROWSET, ST_RAS, ST_COLSW, ST_CAS, ST_DATA, ST_PRE
    } seq_state_e;

    typedef enum logic [1:0] {
        MA_ZERO, MA_ROW, MA_COL, MA_REF
    } ma_sel_e;
endpackage

// File: rtl/dram_refresh_ctr.sv
module dram_refresh_ctr #(
    parameter int W = 9
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         step,
    output logic [W-1:0] row
);
    logic [W-1:0] row_d, row_q;

    always_comb begin
        row_d = row_q;
        if (step) row_d = row_q + W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) row_q <= '0;
        else        row_q <= row_d;
    end

    assign row = row_q;
endmodule

// File: rtl/dram_bank_decode.sv
module dram_bank_decode #(
    parameter int NUM_BANKS = 5,
    parameter int BANK_W    = 3
) (
    input  logic [BANK_W-1:0]    idx,
    input  logic                 hit_all,
    input  logic                 strobe_en,
    output logic [NUM_BANKS-1:0] ras_n
);
    for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
        assign ras_n[g] = ~(strobe_en & (hit_all | (idx == BANK_W'(g))));
    end
endmodule

// File: rtl/dram_addr_mux.sv
module dram_addr_mux
    import dram_seq_pkg::*;
#(
    parameter int HALF_W = 9
) (
    input  ma_sel_e           sel,
    input  logic [HALF_W-1:0] row,
    input  logic [HALF_W-1:0] col,
    input  logic [HALF_W-1:0] ref_row,
    output logic [MA_W-1:0]   ma
);
    logic [HALF_W-1:0] half;

    always_comb begin
        case (sel)
            MA_ROW:  half = row;
            MA_COL:  half = col;
            MA_REF:  half = ref_row;
            default: half = '0;
        endcase
    end

    if (HALF_W < MA_W) begin : g_narrow
        assign ma = {{(MA_W-HALF_W){1'b0}}, half};
    end else begin : g_full
        assign ma = half[MA_W-1:0];
    end
endmodule

// File: rtl/dram_bank_seq.sv
module dram_bank_seq
    import dram_seq_pkg::*;
#(
    parameter int NUM_BANKS = 5,
    parameter bit WIDE_ADDR = 1'b1,
    parameter int T_SETUP   = 1,
    parameter int T_RAS     = 2,
    parameter int T_COLSW   = 1,
    parameter int T_CAS     = 2,
    parameter int T_DATA    = 1,
    parameter int T_PRE     = 2,
    parameter int CNT_W     = 4,
    localparam int BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
    localparam int HALF_W   = WIDE_ADDR ? 9 : 8,
    localparam int ADDR_W   = BANK_W + 2 * HALF_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    input  logic                 req_write,
    input  logic [ADDR_W-1:0]    req_addr,
    output logic                 req_ack,
    input  logic                 refresh_req,
    input  logic                 ram_sel_n,
    output logic [MA_W-1:0]      ma,
    output logic [NUM_BANKS-1:0] ras_n,
    output logic                 cas_n,
    output logic                 we_n,
    output logic                 xcvr_en_n,
    output logic                 xcvr_dir
);
    typedef struct packed {
        seq_state_e        st;
        logic [CNT_W-1:0]  cnt;
        logic [BANK_W-1:0] bank;
        logic [HALF_W-1:0] row;
        logic [HALF_W-1:0] col;
        logic              wr;
        logic              refr;
        logic              bank_ok;
        logic              pend;
    } seq_t;

    seq_t s_d, s_q;
    logic ack_d;

    function automatic logic [CNT_W-1:0] tload(seq_state_e s);
        case (s)
            ST_ROWSET: return CNT_W'(T_SETUP - 1);
            ST_RAS:    return CNT_W'(T_RAS - 1);
            ST_COLSW:  return CNT_W'(T_COLSW - 1);
            ST_CAS:    return CNT_W'(T_CAS - 1);
            ST_DATA:   return CNT_W'(T_DATA - 1);
            ST_PRE:    return CNT_W'(T_PRE - 1);
            default:   return '0;
        endcase
    endfunction

    always_comb begin
        s_d   = s_q;
        ack_d = 1'b0;
        s_d.pend = s_q.pend | refresh_req;
        if (s_q.st == ST_IDLE) begin
            if (s_q.pend || refresh_req) begin
                s_d.st   = ST_ROWSET;
                s_d.cnt  = tload(ST_ROWSET);
                s_d.refr = 1'b1;
                s_d.wr   = 1'b0;
                s_d.pend = 1'b0;
            end else if (req_valid) begin
                ack_d       = 1'b1;
                s_d.st      = ST_ROWSET;
                s_d.cnt     = tload(ST_ROWSET);
                s_d.refr    = 1'b0;
                s_d.wr      = req_write;
                s_d.col     = req_addr[HALF_W-1:0];
                s_d.row     = req_addr[2*HALF_W-1:HALF_W];
                s_d.bank    = req_addr[ADDR_W-1:2*HALF_W];
                s_d.bank_ok = (int'(req_addr[ADDR_W-1:2*HALF_W]) < NUM_BANKS);
            end
        end else if (s_q.cnt != '0) begin
            s_d.cnt = s_q.cnt - CNT_W'(1);
        end else begin
            case (s_q.st)
                ST_ROWSET: s_d.st = ST_RAS;
                ST_RAS:    s_d.st = s_q.refr ? ST_PRE : ST_COLSW;
                ST_COLSW:  s_d.st = ST_CAS;
                ST_CAS:    s_d.st = ST_DATA;
                ST_DATA:   s_d.st = ST_PRE;
                default:   s_d.st = ST_IDLE;
            endcase
            s_d.cnt = tload(s_d.st);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{st: ST_IDLE, default: '0};
        end else begin
            s_q <= s_d;
        end
    end

    logic              ras_phase, col_phase, wr_phase, cpu_live, ref_step;
    ma_sel_e           ma_sel;
    logic [HALF_W-1:0] ref_row;

    assign cpu_live  = !s_q.refr && s_q.bank_ok;
    assign ras_phase = s_q.st inside {ST_RAS, ST_COLSW, ST_CAS, ST_DATA};
    assign col_phase = cpu_live && (s_q.st inside {ST_CAS, ST_DATA});
    assign wr_phase  = cpu_live && s_q.wr && (s_q.st inside {ST_COLSW, ST_CAS, ST_DATA});
    assign ref_step  = s_q.refr && (s_q.st == ST_RAS) && (s_q.cnt == '0);

    always_comb begin
        case (s_q.st)
            ST_ROWSET, ST_RAS:       ma_sel = s_q.refr ? MA_REF : MA_ROW;
            ST_COLSW, ST_CAS, ST_DATA: ma_sel = MA_COL;
            default:                 ma_sel = MA_ZERO;
        endcase
    end

    dram_refresh_ctr #(.W(HALF_W)) u_ref (
        .clk(clk), .rst_n(rst_n), .step(ref_step), .row(ref_row)
    );

    dram_bank_decode #(.NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W)) u_dec (
        .idx(s_q.bank), .hit_all(s_q.refr),
        .strobe_en(ras_phase && (s_q.refr || s_q.bank_ok)), .ras_n(ras_n)
    );

    dram_addr_mux #(.HALF_W(HALF_W)) u_mux (
        .sel(ma_sel), .row(s_q.row), .col(s_q.col), .ref_row(ref_row), .ma(ma)
    );

    assign req_ack   = ack_d;
    assign cas_n     = ~col_phase;
    assign we_n      = ~wr_phase;
    assign xcvr_en_n = ram_sel_n | ~col_phase;
    assign xcvr_dir  = s_q.wr && !s_q.refr && (s_q.st != ST_IDLE);

    // R2: during the column phase exactly one bank is strobed
    a_r2_single_bank: assert property (@(posedge clk) disable iff (!rst_n)
        !cas_n |-> ($countones(~ras_n) == 1));

    // R9: all-bank strobing never comes with a column strobe
    a_r9_refresh_no_cas: assert property (@(posedge clk) disable iff (!rst_n)
        (ras_n == '0) |-> cas_n);

    // R4: the row half was already on the bus before the row strobe fell
    a_r4_row_setup: assert property (@(posedge clk) disable iff (!rst_n)
        ((ras_n != '1) && ($past(ras_n) == '1)) |-> $stable(ma));

    // R8: the row strobes do not move when the column strobe falls
    a_r8_ras_held_at_cas: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cas_n) |-> $stable(ras_n));

    // R7: transceiver enabled only with column strobe and RAM select
    a_r7_xcvr_gate: assert property (@(posedge clk) disable iff (!rst_n)
        !xcvr_en_n |-> (!cas_n && !ram_sel_n));
endmodule

// File: tb/dram_bank_seq_tb.sv
`timescale 1ns/1ps
module dram_bank_seq_tb;
    localparam int T_RAS = 2, T_COLSW = 1, T_CAS = 2, T_DATA = 1, T_PRE = 2, T_SETUP = 1;
    localparam int CPU_LEN = T_RAS + T_COLSW + T_CAS + T_DATA;

    logic clk = 1'b0, rst_n = 1'b0;
    always #2 clk = ~clk;

    logic       req_valid = 0, req_write = 0, refresh_req = 0, ram_sel_n = 0;
    logic [2:0] b = 0;
    logic [8:0] r = 0, c = 0;
    logic [20:0] addr;
    logic [18:0] n_addr;
    assign addr   = {b, r, c};
    assign n_addr = {b, r[7:0], c[7:0]};

    logic       req_ack, cas_n, we_n, xcvr_en_n, xcvr_dir;
    logic [8:0] ma;
    logic [4:0] ras_n;
    logic       n_ack, n_cas, n_we, n_en, n_dir;
    logic [8:0] n_ma;
    logic [4:0] n_ras;

    dram_bank_seq u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(addr), .req_ack(req_ack), .refresh_req(refresh_req),
        .ram_sel_n(ram_sel_n), .ma(ma), .ras_n(ras_n), .cas_n(cas_n),
        .we_n(we_n), .xcvr_en_n(xcvr_en_n), .xcvr_dir(xcvr_dir)
    );

    dram_bank_seq #(.WIDE_ADDR(1'b0)) u_dut_narrow (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(n_addr), .req_ack(n_ack), .refresh_req(refresh_req),
        .ram_sel_n(ram_sel_n), .ma(n_ma), .ras_n(n_ras), .cas_n(n_cas),
        .we_n(n_we), .xcvr_en_n(n_en), .xcvr_dir(n_dir)
    );

    typedef struct {
        logic [4:0] ras;
        logic [8:0] ma_row;
        logic [8:0] ma_col;
        int         len;
        int         start;
        int         stop;
        bit         cas_seen;
        bit         stable;
        bit         en_ok;
        logic       we;
        logic       dir;
    } ep_t;

    ep_t eps[$];
    ep_t cur;
    bit  in_ep = 0, stray = 0, n_hi8 = 0, n_cas_prev = 1;
    int  cyc = 0;
    logic [8:0] n_col = 0;
    int  n_chk = 0, n_fail = 0, ref_exp = 0;
    bit  finished = 0;

    always @(negedge clk) if (rst_n) begin
        cyc++;
        if (!in_ep) begin
            if (ras_n != 5'h1f) begin
                in_ep = 1;
                cur.ras = ras_n; cur.ma_row = ma; cur.ma_col = 0; cur.len = 1;
                cur.start = cyc; cur.stop = 0; cur.cas_seen = 0; cur.stable = 1;
                cur.en_ok = 1; cur.we = 1; cur.dir = 0;
            end
        end else if (ras_n == 5'h1f) begin
            in_ep = 0;
            cur.stop = cyc;
            eps.push_back(cur);
        end else begin
            cur.len++;
            if (ras_n != cur.ras) cur.stable = 0;
        end
        if (in_ep) begin
            if (!cas_n && !cur.cas_seen) begin
                cur.cas_seen = 1; cur.ma_col = ma; cur.we = we_n; cur.dir = xcvr_dir;
            end
            if (!cas_n) begin
                if (xcvr_en_n != ram_sel_n) cur.en_ok = 0;
            end else if (!xcvr_en_n) cur.en_ok = 0;
            if (cas_n && !we_n && !cur.cas_seen && ras_n == 5'h00) cur.en_ok = 0;
        end else begin
            if (!cas_n || !xcvr_en_n || !we_n) stray = 1;
        end
        if (n_ma[8]) n_hi8 = 1;
        if (!n_cas && n_cas_prev) n_col = n_ma;
        n_cas_prev = n_cas;
    end

    task automatic chk(bit ok, string req, string what, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic wait_neg(int n);
        repeat (n) @(negedge clk);
    endtask

    // hold the request until acknowledged, then drop it
    task automatic issue(int bank, int row, int col, bit wr, bit sel_n);
        @(negedge clk);
        b = 3'(bank); r = 9'(row); c = 9'(col); req_write = wr; ram_sel_n = sel_n;
        req_valid = 1;
        for (int k = 0; k < 60; k++) begin
            #1;
            if (req_ack) break;
            @(negedge clk);
        end
        @(negedge clk);
        req_valid = 0;
    endtask

    task automatic check_cpu(ep_t e, int bank, int row, int col, bit wr, bit sel_n);
        chk(e.ras == ~(5'b1 << bank), "R2", "row strobe pattern", e.ras, ~(5'b1 << bank) & 5'h1f);
        chk(e.stable, "R2", "strobe held", e.stable, 1);
        chk(e.ma_row == 9'(row), "R4", "row at strobe fall", e.ma_row, row);
        chk(e.cas_seen && e.ma_col == 9'(col), "R4", "col at cas fall", e.ma_col, col);
        chk(e.we == !wr, "R6", "write enable", e.we, !wr);
        chk(e.dir == wr, "R7", "transceiver dir", e.dir, wr);
        chk(e.en_ok, "R7", "transceiver gating", e.en_ok, 1);
        chk(e.len == CPU_LEN, "R8", "row strobe width", e.len, CPU_LEN);
    endtask

    task automatic check_ref(ep_t e);
        chk(e.ras == 5'h00, "R9", "all banks strobed", e.ras, 0);
        chk(!e.cas_seen, "R9", "no column strobe", e.cas_seen, 0);
        chk(e.len == T_RAS, "R9", "refresh strobe width", e.len, T_RAS);
        chk(e.ma_row == 9'(ref_exp), "R10", "refresh row", e.ma_row, ref_exp);
        ref_exp = (ref_exp + 1) % 512;
    endtask

    task automatic cpu_op(int bank, int row, int col, bit wr, bit sel_n);
        int n0;
        n0 = eps.size();
        stray = 0;
        issue(bank, row, col, wr, sel_n);
        wait_neg(14);
        if (bank < 5) begin
            chk(eps.size() == n0 + 1, "R2", "one cycle recorded", eps.size() - n0, 1);
            if (eps.size() == n0 + 1) check_cpu(eps[n0], bank, row, col, wr, sel_n);
            chk(n_col[7:0] == 8'(col), "R5", "narrow column", n_col[7:0], col & 255);
        end else begin
            chk(eps.size() == n0, "R3", "no strobes for bad bank", eps.size() - n0, 0);
            chk(!stray, "R3", "no cas/we/xcvr for bad bank", stray, 0);
        end
    endtask

    task automatic ref_op();
        int n0;
        n0 = eps.size();
        @(negedge clk);
        refresh_req = 1;
        @(negedge clk);
        refresh_req = 0;
        wait_neg(8);
        chk(eps.size() == n0 + 1, "R9", "refresh recorded", eps.size() - n0, 1);
        if (eps.size() == n0 + 1) check_ref(eps[n0]);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int n0;
        int ack_seen;
        void'($urandom(32'd2024));
        wait_neg(3);
        rst_n = 1;
        @(negedge clk); #1;
        // R1 reset state
        chk(ras_n == 5'h1f, "R1", "ras idle", ras_n, 5'h1f);
        chk(cas_n && we_n && xcvr_en_n, "R1", "cas/we/en idle", {cas_n, we_n, xcvr_en_n}, 7);
        chk(ma == 0 && !req_ack, "R1", "ma/ack idle", ma, 0);

        // directed: every bank, top bits of halves
        for (int k = 0; k < 5; k++) cpu_op(k, 9'h1a5 ^ k, 9'h15a + k, k[0], 0);
        cpu_op(2, 9'h100, 9'h0ff, 1, 0);
        chk(eps[eps.size()-1].ma_row[8], "R5", "wide ma[8] used", eps[eps.size()-1].ma_row[8], 1);
        cpu_op(4, 0, 9'h1ff, 0, 1);
        for (int k = 5; k < 8; k++) cpu_op(k, 3, 4, 1, 0);
        #1;
        chk(ras_n == 5'h1f && cas_n && ma == 0, "R1", "idle after cycles", ras_n, 5'h1f);

        ref_op();
        ref_op();

        // R11: refresh and request in the same idle cycle
        n0 = eps.size();
        @(negedge clk);
        b = 1; r = 9'h0c3; c = 9'h13c; req_write = 1; ram_sel_n = 0;
        req_valid = 1; refresh_req = 1;
        #1;
        chk(!req_ack, "R11", "ack withheld", req_ack, 0);
        @(negedge clk);
        refresh_req = 0;
        ack_seen = 0;
        for (int k = 0; k < 40 && !ack_seen; k++) begin
            #1;
            if (req_ack) begin
                ack_seen = 1;
                chk(eps.size() == n0 + 1, "R11", "refresh done before ack", eps.size() - n0, 1);
            end
            @(negedge clk);
        end
        req_valid = 0;
        wait_neg(14);
        chk(eps.size() == n0 + 2, "R11", "two cycles", eps.size() - n0, 2);
        if (eps.size() == n0 + 2) begin
            check_ref(eps[n0]);
            check_cpu(eps[n0+1], 1, 9'h0c3, 9'h13c, 1, 0);
        end

        // R12: refresh arriving inside a processor cycle
        n0 = eps.size();
        issue(3, 9'h055, 9'h0aa, 0, 0);
        wait_neg(2);
        refresh_req = 1;
        @(negedge clk);
        refresh_req = 0;
        wait_neg(20);
        chk(eps.size() == n0 + 2, "R12", "cycle then refresh", eps.size() - n0, 2);
        if (eps.size() == n0 + 2) begin
            check_cpu(eps[n0], 3, 9'h055, 9'h0aa, 0, 0);
            check_ref(eps[n0+1]);
            chk(eps[n0+1].start - eps[n0].stop == T_PRE + 1 + T_SETUP, "R8", "precharge gap",
                eps[n0+1].start - eps[n0].stop, T_PRE + 1 + T_SETUP);
        end

        // constrained random traffic
        for (int k = 0; k < 80; k++) begin
            cpu_op($urandom % 8, $urandom % 512, $urandom % 512, 1'($urandom), 1'($urandom % 4 == 0));
            if (k % 7 == 3) ref_op();
        end

        // R10: wrap of the refresh row counter
        for (int k = 0; k < 515; k++) ref_op();

        chk(!n_hi8, "R5", "narrow ma[8] never set", n_hi8, 0);

        finished = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end
endmodule